// File: doc/BRIEF.md
# Single-Precision Significand Rounder

This combinational stage takes a value that is already split into sign, signed unbiased exponent and a 53-bit significand, and rounds it to 24 significant bits. The integer bit is the most significant bit of the significand. Three further bits from below the significand can also be supplied. Any of them that is set makes the value inexact. A 2-bit mode input picks one of four rounding directions.

The stage returns three things. The first is the exponent, adjusted when rounding carries out of the kept field. The second is the rounded significand, with every bit below the kept field cleared. The third is a pair of status bits: one reports that the kept field was incremented, the other that nonzero bits were discarded. Overflow and underflow detection, packing of the result and exception handling belong to the consumer that follows this stage.

Top module: `sp_sig_rounder`

## Requirements
- R1: Mode encoding is 00 nearest-even, 01 toward zero, 10 toward +infinity and 11 toward -infinity. In mode 01 the kept field is never incremented.
- R2: The 29 significand bits below the kept field, followed by the three extra bits, form a 32-bit remainder. In mode 00 the kept field is incremented when this remainder is above one half (only its top bit set). It is also incremented when the remainder is exactly one half and the kept field's lowest bit (`sig_i[29]`) is 1.
- R3: In mode 10 the kept field is incremented when `sign_i` is 0 and any discarded bit is set.
- R4: In mode 11 the kept field is incremented when `sign_i` is 1 and any discarded bit is set.
- R5: Every bit of `sig_i[26:0]` and of `extra_i` counts toward the discarded part, in the same way as the guard bit `sig_i[28]` and the round bit `sig_i[27]`.
- R6: If the increment carries out of the 24-bit kept field, `sig_o[52:29]` becomes a 1 followed by 23 zeros and `exp_o` is `exp_i` plus one.
- R7: `sig_o[28:0]` is always zero. Without a carry-out, `sig_o[52:29]` equals `sig_i[52:29]` plus the increment.
- R8: `rounded_o` is 1 exactly when the kept field was incremented.
- R9: `inexact_o` is 1 exactly when some discarded bit (significand bits 28..0 or any extra bit) is set.
- R10: When there is no carry-out, `exp_o` equals `exp_i`, read as a 12-bit two's complement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value, 1 for negative |
| exp_i | input | 12 | Signed unbiased exponent |
| sig_i | input | 53 | Significand, integer bit at bit 52 |
| extra_i | input | 3 | Extra low-order bits below the significand |
| mode_i | input | 2 | Rounding direction |
| exp_o | output | 12 | Exponent after rounding |
| sig_o | output | 53 | Rounded significand, bits 28..0 zero |
| rounded_o | output | 1 | Kept field was incremented |
| inexact_o | output | 1 | Discarded part was nonzero |

## Verification
Exact inputs are applied under all four modes to confirm that no mode rounds a value with nothing discarded. Remainders just below, exactly at and just above one half are applied with both even and odd kept fields; this separates ties-to-even from plain round-half-up and from truncation. Both signs are applied under the two directed modes to show that only the sign facing the rounding direction increments. A lone set bit is placed in the low significand bits and in each extra bit to confirm the sticky fold. An all-ones kept field forces the carry-out path, and a sweep of pseudo-random vectors in every mode is compared against an arithmetic model of the remainder.

// File: rtl/sprnd_pkg.sv
package sprnd_pkg;

    localparam int unsigned SIG_W_DEF  = 53;
    localparam int unsigned KEEP_W_DEF = 24;
    localparam int unsigned XTRA_W_DEF = 3;
    localparam int unsigned EXP_W_DEF  = 12;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_UP        = 2'b10,
        RM_DOWN      = 2'b11
    } rmode_e;

    // Bits around the cut point of the significand
    typedef struct packed {
        logic lsb;
        logic guard;
        logic rnd;
        logic sticky;
    } tail_t;

    function automatic logic tail_nonzero(tail_t t);
        return t.guard | t.rnd | t.sticky;
    endfunction

endpackage

// File: rtl/sprnd_tail.sv
module sprnd_tail
    import sprnd_pkg::*;
#(
    parameter int unsigned SIG_W  = SIG_W_DEF,
    parameter int unsigned KEEP_W = KEEP_W_DEF,
    parameter int unsigned XTRA_W = XTRA_W_DEF
) (
    input  logic [SIG_W-1:0]  sig_i,
    input  logic [XTRA_W-1:0] extra_i,
    output logic [KEEP_W-1:0] kept_o,
    output tail_t             tail_o
);
    localparam int unsigned DROP_W = SIG_W - KEEP_W;

    logic low_any;
    logic ext_any;

    assign low_any = |sig_i[DROP_W-3:0];

    generate
        if (XTRA_W > 0) begin : g_ext
            assign ext_any = |extra_i;
        end else begin : g_noext
            assign ext_any = 1'b0;
        end
    endgenerate

    always_comb begin
        kept_o        = sig_i[SIG_W-1 -: KEEP_W];
        tail_o.lsb    = sig_i[DROP_W];
        tail_o.guard  = sig_i[DROP_W-1];
        tail_o.rnd    = sig_i[DROP_W-2];
        tail_o.sticky = low_any | ext_any;
    end

    // R5: any set extra bit must reach the sticky bit
    always_comb begin
        if (|extra_i) a_r5_extra_sticky: assert (tail_o.sticky);
    end

endmodule

// File: rtl/sprnd_decide.sv
module sprnd_decide
    import sprnd_pkg::*;
(
    input  logic   sign_i,
    input  rmode_e mode_i,
    input  tail_t  tail_i,
    output logic   inc_o
);
    logic lost;

    assign lost = tail_nonzero(tail_i);

    always_comb begin
        unique case (mode_i)
            RM_NEAR_EVEN: inc_o = tail_i.guard & (tail_i.lsb | tail_i.rnd | tail_i.sticky);
            RM_TO_ZERO:   inc_o = 1'b0;
            RM_UP:        inc_o = ~sign_i & lost;
            RM_DOWN:      inc_o = sign_i & lost;
            default:      inc_o = 1'b0;
        endcase
    end

    // R2: without a guard bit, nearest mode never rounds up
    always_comb begin
        if (mode_i == RM_NEAR_EVEN && !tail_i.guard)
            a_r2_no_guard_no_inc: assert (!inc_o);
    end

endmodule

// File: rtl/sprnd_apply.sv
module sprnd_apply #(
    parameter int unsigned SIG_W  = 53,
    parameter int unsigned KEEP_W = 24,
    parameter int unsigned EXP_W  = 12
) (
    input  logic [KEEP_W-1:0] kept_i,
    input  logic              inc_i,
    input  logic [EXP_W-1:0]  exp_i,
    output logic [EXP_W-1:0]  exp_o,
    output logic [SIG_W-1:0]  sig_o
);
    localparam int unsigned DROP_W = SIG_W - KEEP_W;

    logic [KEEP_W:0]   sum;
    logic              carry;
    logic [KEEP_W-1:0] kept_n;

    always_comb begin
        sum    = {1'b0, kept_i} + {{KEEP_W{1'b0}}, inc_i};
        carry  = sum[KEEP_W];
        kept_n = carry ? {1'b1, sum[KEEP_W-1:1]} : sum[KEEP_W-1:0];
        exp_o  = exp_i + {{(EXP_W-1){1'b0}}, carry};
        sig_o  = {kept_n, {DROP_W{1'b0}}};
    end

    // R6: a carry can only come from an all-ones kept field
    always_comb begin
        if (carry) a_r6_carry_from_ones: assert (&kept_i && inc_i);
    end

endmodule

// File: rtl/sp_sig_rounder.sv
module sp_sig_rounder
    import sprnd_pkg::*;
#(
    parameter int unsigned SIG_W  = SIG_W_DEF,
    parameter int unsigned KEEP_W = KEEP_W_DEF,
    parameter int unsigned XTRA_W = XTRA_W_DEF,
    parameter int unsigned EXP_W  = EXP_W_DEF
) (
    input  logic              sign_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [SIG_W-1:0]  sig_i,
    input  logic [XTRA_W-1:0] extra_i,
    input  logic [1:0]        mode_i,
    output logic [EXP_W-1:0]  exp_o,
    output logic [SIG_W-1:0]  sig_o,
    output logic              rounded_o,
    output logic              inexact_o
);
    localparam int unsigned DROP_W = SIG_W - KEEP_W;

    rmode_e            mode;
    tail_t             tail;
    logic [KEEP_W-1:0] kept;
    logic              inc;

    assign mode = rmode_e'(mode_i);

    sprnd_tail #(.SIG_W(SIG_W), .KEEP_W(KEEP_W), .XTRA_W(XTRA_W)) u_tail (
        .sig_i   (sig_i),
        .extra_i (extra_i),
        .kept_o  (kept),
        .tail_o  (tail)
    );

    sprnd_decide u_decide (
        .sign_i (sign_i),
        .mode_i (mode),
        .tail_i (tail),
        .inc_o  (inc)
    );

    sprnd_apply #(.SIG_W(SIG_W), .KEEP_W(KEEP_W), .EXP_W(EXP_W)) u_apply (
        .kept_i (kept),
        .inc_i  (inc),
        .exp_i  (exp_i),
        .exp_o  (exp_o),
        .sig_o  (sig_o)
    );

    assign rounded_o = inc;
    assign inexact_o = tail_nonzero(tail);

    always_comb begin
        // R8: an increment only happens when something was discarded
        if (rounded_o) a_r8_round_needs_loss: assert (inexact_o);
        // R1: toward-zero mode leaves the kept field alone
        if (mode_i == 2'b01) a_r1_zero_mode_holds: assert (!rounded_o);
        // R3: toward +inf never increments a negative value
        if (mode_i == 2'b10 && sign_i) a_r3_up_skips_negative: assert (!rounded_o);
        // R4: toward -inf never increments a positive value
        if (mode_i == 2'b11 && !sign_i) a_r4_down_skips_positive: assert (!rounded_o);
        // R10: exponent moves only on a rounded carry
        if (exp_o != exp_i) a_r10_exp_moves_on_round: assert (rounded_o && sig_o[SIG_W-1]);
        // R7: discarded region is cleared
        a_r7_low_clear: assert (sig_o[DROP_W-1:0] == '0);
    end

endmodule

// File: tb/tb_sp_sig_rounder.sv
module tb_sp_sig_rounder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic        sign_i;
    logic [11:0] exp_i;
    logic [52:0] sig_i;
    logic [2:0]  extra_i;
    logic [1:0]  mode_i;
    logic [11:0] exp_o;
    logic [52:0] sig_o;
    logic        rounded_o;
    logic        inexact_o;

    int n_run  = 0;
    int n_fail = 0;

    sp_sig_rounder dut (
        .sign_i    (sign_i),
        .exp_i     (exp_i),
        .sig_i     (sig_i),
        .extra_i   (extra_i),
        .mode_i    (mode_i),
        .exp_o     (exp_o),
        .sig_o     (sig_o),
        .rounded_o (rounded_o),
        .inexact_o (inexact_o)
    );

    // Arithmetic model: 32-bit remainder compared against one half
    task automatic model(input logic s, input logic [11:0] e, input logic [52:0] m,
                         input logic [2:0] x, input logic [1:0] md,
                         output logic [11:0] ee, output logic [52:0] mm,
                         output logic rr, output logic ii);
        logic [31:0] rem;
        logic [24:0] k;
        rem = {m[28:0], x};
        k   = {1'b0, m[52:29]};
        ii  = (rem != 32'd0);
        case (md)
            2'b00:   rr = (rem > 32'h8000_0000) || (rem == 32'h8000_0000 && k[0]);
            2'b01:   rr = 1'b0;
            2'b10:   rr = !s && ii;
            default: rr = s && ii;
        endcase
        k  = k + 25'(rr);
        ee = e;
        if (k[24]) begin
            k  = 25'h080_0000;
            ee = e + 12'd1;
        end
        mm = {k[23:0], 29'd0};
    endtask

    task automatic apply_check(input string tag, input logic s, input logic [11:0] e,
                               input logic [52:0] m, input logic [2:0] x, input logic [1:0] md);
        logic [11:0] ee;
        logic [52:0] mm;
        logic rr, ii;
        @(negedge clk);
        sign_i = s; exp_i = e; sig_i = m; extra_i = x; mode_i = md;
        #1;
        model(s, e, m, x, md, ee, mm, rr, ii);
        n_run++;
        if (exp_o !== ee || sig_o !== mm || rounded_o !== rr || inexact_o !== ii) begin
            n_fail++;
            $display("FAIL %s mode=%b: got exp=%h sig=%h r=%b i=%b, expected exp=%h sig=%h r=%b i=%b",
                     tag, md, exp_o, sig_o, rounded_o, inexact_o, ee, mm, rr, ii);
        end
    endtask

    localparam logic [52:0] ONE  = 53'h10_0000_0000_0000;
    localparam logic [52:0] HALF = 53'h00_0000_1000_0000; // bit 28 only

    task automatic t_idle;   // R9 R10: all-zero input
        apply_check("R9_R10_idle", 1'b0, 12'd0, 53'd0, 3'd0, 2'b00);
    endtask

    task automatic t_exact;  // R1 R7 R10: nothing discarded in any mode
        for (int md = 0; md < 4; md++) begin
            apply_check("R7_exact", 1'b0, 12'd5, ONE | 53'h0_1234_6000_0000, 3'd0, 2'(md));
            apply_check("R10_exact_neg", 1'b1, 12'hF80, ONE | (53'd1 << 29), 3'd0, 2'(md));
        end
    endtask

    task automatic t_nearest; // R2: below, at and above half, even and odd lsb
        apply_check("R2_tie_even",  1'b0, 12'd1, ONE | HALF, 3'd0, 2'b00);
        apply_check("R2_tie_odd",   1'b0, 12'd1, ONE | (53'd1 << 29) | HALF, 3'd0, 2'b00);
        apply_check("R2_above",     1'b0, 12'd1, ONE | HALF | 53'd1, 3'd0, 2'b00);
        apply_check("R2_below",     1'b1, 12'd1, ONE | (HALF - 53'd1), 3'd7, 2'b00);
        apply_check("R2_tie_extra", 1'b0, 12'd1, ONE | HALF, 3'b001, 2'b00);
    endtask

    task automatic t_directed; // R1 R3 R4 R8 R9
        for (int s = 0; s < 2; s++) begin
            apply_check("R1_to_zero", 1'(s), 12'd3, ONE | 53'h1FFF_FFFF, 3'd7, 2'b01);
            apply_check("R3_up",      1'(s), 12'd3, ONE | 53'd4, 3'd0, 2'b10);
            apply_check("R4_down",    1'(s), 12'd3, ONE | 53'd4, 3'd0, 2'b11);
            apply_check("R8_R9_round_bit", 1'(s), 12'd3, ONE | (53'd1 << 27), 3'd0, 2'b10);
        end
    endtask

    task automatic t_sticky; // R5: lone low bit, each extra bit
        apply_check("R5_low_bit", 1'b0, 12'd0, ONE, 3'd0, 2'b10);
        apply_check("R5_low_bit", 1'b0, 12'd0, ONE | 53'd1, 3'd0, 2'b10);
        for (int b = 0; b < 3; b++) begin
            apply_check("R5_extra_bit", 1'b1, 12'd0, ONE, 3'(1 << b), 2'b11);
            apply_check("R5_extra_tie", 1'b0, 12'd0, ONE | HALF, 3'(1 << b), 2'b00);
        end
    endtask

    task automatic t_carry; // R6: all-ones kept field rolls over
        logic [52:0] ones;
        ones = {24'hFF_FFFF, 29'd0};
        apply_check("R6_carry_near", 1'b0, 12'd127, ones | HALF | 53'd1, 3'd0, 2'b00);
        apply_check("R6_carry_up",   1'b0, 12'hFFF, ones | 53'd1, 3'd0, 2'b10);
        apply_check("R6_carry_down", 1'b1, 12'h800, ones, 3'd1, 2'b11);
        apply_check("R6_no_carry",   1'b0, 12'd127, ones, 3'd1, 2'b10 ^ 2'b11);
    endtask

    task automatic t_sweep; // R1..R10 against the model
        for (int i = 0; i < 600; i++) begin
            logic [52:0] m;
            m = {$urandom(), $urandom()};
            if (i % 5 == 0) m[52:29] = 24'hFF_FFFF;
            if (i % 7 == 0) m[27:0] = 28'd0;
            apply_check("R2_R3_R4_R6_sweep", 1'($urandom()), 12'($urandom() % 300),
                        m, 3'($urandom()), 2'(i % 4));
        end
    endtask

    initial begin
        sign_i = 1'b0; exp_i = '0; sig_i = '0; extra_i = '0; mode_i = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_exact();
        t_nearest();
        t_directed();
        t_sticky();
        t_carry();
        t_sweep();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule